// File: doc/BRIEF.md
# Single-Wire Pulse-Width Line Controller

This block drives the master-to-slave line of a full-duplex single-wire link and, in the same bit periods, reads the reply that comes back from the slave. Each outgoing bit takes one bit period of programmable length. The line rises at the start of the period. For a data 0 or an idle bit it falls after one quarter of the period, and for a data 1 it falls after three quarters. The slave's answer reaches the block as a digital "current drawn" input. That input is sampled once per period, at a point where the line is high for either coding.

The block also keeps the bus state. The bus can be off, with the line low. It can be suspended, with the line held high. It can be resuming, where the master sends a low transition period and then eight idle bits. Or it can be active. A slave can also wake a suspended bus by drawing current. The block then goes straight to active, starts toggling the line, and sets a sticky wake flag. A framer upstream offers transmit bits through a ready/valid handshake. Whenever it offers no bit, idle bits go out.

Top module: `swl_line_ctrl`

## Requirements
- R1: After reset, bus_state_o is 0 (off), s1_o is low, and tx_ready_o, rx_valid_o and wake_o are all low.
- R2: In the off state (code 0), a pulse on link_en_i moves the bus to suspended (code 1) on the next clock. While suspended, s1_o is held high.
- R3: A pulse on resume_i while suspended moves the bus to resuming (code 2). The block then drives one bit period (4*quarter_len clocks) with s1_o low, followed by 8 idle bit periods. After these the bus is active (code 3).
- R4: Every bit period lasts 4*quarter_len clocks and starts with s1_o high. s1_o stays high for quarter_len clocks for a 0 or idle bit, and for 3*quarter_len clocks for a 1 bit. It is low for the rest of the period.
- R5: If tx_valid_i is low when a bit is taken, the following period carries an idle (0-coded) bit.
- R6: tx_ready_o is high for exactly one clock, on the last clock of a period, and only when the next period belongs to the active state. tx_bit_i is accepted in that clock and sent in the following period.
- R7: In each active period, s2_i is sampled on the clock where the position within the period equals quarter_len/2 (rounded down). rx_valid_o is high for one clock on the following cycle, with rx_bit_o equal to the sampled value.
- R8: A high s2_i while suspended moves the bus to active on the next clock and sets wake_o. wake_o stays high until wake_clr_i is asserted.
- R9: suspend_i and deact_i take effect only at the end of an active period. deact_i takes priority and moves the bus to off (code 0). suspend_i alone moves it to suspended (code 1).
- R10: In the off state, s2_i has no effect on the bus state or on wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quarter_len | input | QW | Quarter of the bit period in clocks, at least 1 |
| link_en_i | input | 1 | Request to leave the off state |
| resume_i | input | 1 | Master resume request |
| suspend_i | input | 1 | Return to suspended at the end of the period |
| deact_i | input | 1 | Return to off (at the end of the period when running) |
| wake_clr_i | input | 1 | Clears the wake flag |
| tx_valid_i | input | 1 | Framer offers a bit |
| tx_bit_i | input | 1 | Bit offered by the framer |
| tx_ready_o | output | 1 | Bit accepted this clock |
| s2_i | input | 1 | Slave current-drawn indication |
| s1_o | output | 1 | Master-to-slave line |
| rx_valid_o | output | 1 | Received bit strobe |
| rx_bit_o | output | 1 | Received bit |
| bus_state_o | output | 2 | 0 off, 1 suspended, 2 resuming, 3 active |
| wake_o | output | 1 | Sticky slave-resume flag |

## Verification
If the period counter is wrong, the next bit period shows it at s1_o: a pulse width or period length differs from quarter_len multiples. An error in the bus state machine appears within one period as a wrong bus_state_o code, or as a line level that breaks the fixed low/high rule for the off and suspended states. If the bit latch or the sample point is misplaced, tx_ready_o moves off the period's last clock, or the rx_valid_o strobe lands on a different clock or carries a stale value, in the same period.

// File: rtl/swl_pkg.sv
package swl_pkg;

  typedef enum logic [1:0] {
    BUS_OFF    = 2'd0,
    BUS_SUSP   = 2'd1,
    BUS_RESUME = 2'd2,
    BUS_ACTIVE = 2'd3
  } bus_state_e;

  // clocks in one bit period
  function automatic int unsigned period_len(input int unsigned q);
    return 4 * q;
  endfunction

  // position where the line falls for the given bit value
  function automatic int unsigned fall_point(input int unsigned q, input logic b);
    return b ? 3 * q : q;
  endfunction

  // position where the return channel is sampled
  function automatic int unsigned sample_point(input int unsigned q);
    return q >> 1;
  endfunction

endpackage

// File: rtl/swl_bit_timer.sv
module swl_bit_timer #(
  parameter int QW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [QW-1:0]       quarter_len,
  input  swl_pkg::bus_state_e state,
  output logic [QW+1:0]       cnt,
  output logic                period_end
);
  localparam int CW = QW + 2;

  logic [CW-1:0] cnt_q;

  assign period_end = run &&
    ((32'(cnt_q) + 32'd1) >= swl_pkg::period_len(32'(quarter_len)));
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!run || period_end) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4: a period that ends restarts at position zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt_q == '0));

  // R2: the counter is parked while the bus is off
  p_off_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == swl_pkg::BUS_OFF) |-> (cnt_q == '0));

endmodule

// File: rtl/swl_bus_fsm.sv
module swl_bus_fsm #(
  parameter int RESUME_IDLE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_en,
  input  logic                resume_req,
  input  logic                suspend_req,
  input  logic                deact_req,
  input  logic                wake_clr,
  input  logic                s2_i,
  input  logic                period_end,
  output swl_pkg::bus_state_e state,
  output swl_pkg::bus_state_e state_nxt,
  output logic                transition,
  output logic                wake
);
  import swl_pkg::*;

  localparam int IW = $clog2(RESUME_IDLE + 1);

  bus_state_e    state_q, nxt;
  logic [IW-1:0] idx_q;
  logic          slave_wake;
  logic          wake_q;

  always_comb begin
    nxt        = state_q;
    slave_wake = 1'b0;
    unique case (state_q)
      BUS_OFF:    if (link_en) nxt = BUS_SUSP;
      BUS_SUSP: begin
        if (deact_req)       nxt = BUS_OFF;
        else if (s2_i) begin
          nxt        = BUS_ACTIVE;
          slave_wake = 1'b1;
        end
        else if (resume_req) nxt = BUS_RESUME;
      end
      BUS_RESUME: if (period_end) begin
        if (deact_req)                        nxt = BUS_OFF;
        else if (idx_q == IW'(RESUME_IDLE))   nxt = BUS_ACTIVE;
      end
      BUS_ACTIVE: if (period_end) begin
        if (deact_req)        nxt = BUS_OFF;
        else if (suspend_req) nxt = BUS_SUSP;
      end
      default: nxt = BUS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUS_OFF;
      idx_q   <= '0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q != BUS_RESUME) idx_q <= '0;
      else if (period_end)       idx_q <= idx_q + 1'b1;
      if (slave_wake)            wake_q <= 1'b1;
      else if (wake_clr)         wake_q <= 1'b0;
    end
  end

  assign state      = state_q;
  assign state_nxt  = nxt;
  assign transition = (state_q == BUS_RESUME) && (idx_q == '0);
  assign wake       = wake_q;

  // R8: wake flag holds until cleared
  p_wake_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !wake_clr) |=> wake_q);

  // R8: slave current in suspend activates the bus
  p_slave_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BUS_SUSP && s2_i && !deact_req) |=> (state_q == BUS_ACTIVE && wake_q));

  // R9: no state change inside an active period
  p_hold_mid_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BUS_ACTIVE && !period_end) |=> (state_q == BUS_ACTIVE));

  // R10: slave current is ignored while off
  p_off_ignores_s2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BUS_OFF && !link_en) |=> (state_q == BUS_OFF));

endmodule

// File: rtl/swl_line_shaper.sv
module swl_line_shaper #(
  parameter int QW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  swl_pkg::bus_state_e state,
  input  swl_pkg::bus_state_e state_nxt,
  input  logic                transition,
  input  logic [QW+1:0]       cnt,
  input  logic                period_end,
  input  logic [QW-1:0]       quarter_len,
  input  logic                tx_valid,
  input  logic                tx_bit,
  input  logic                s2_i,
  output logic                tx_ready,
  output logic                s1,
  output logic                rx_valid,
  output logic                rx_bit
);
  import swl_pkg::*;

  logic cur_bit_q;
  logic sample_hit;
  logic rx_valid_q, rx_bit_q;
  logic high_phase;

  assign tx_ready   = period_end && (state_nxt == BUS_ACTIVE);
  assign high_phase = 32'(cnt) < fall_point(32'(quarter_len), cur_bit_q);
  assign sample_hit = (state == BUS_ACTIVE) &&
                      (32'(cnt) == sample_point(32'(quarter_len)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cur_bit_q <= 1'b0;
    else if (tx_ready)           cur_bit_q <= tx_valid & tx_bit;
    else if (state != BUS_ACTIVE) cur_bit_q <= 1'b0;
  end

  always_comb begin
    unique case (state)
      BUS_OFF:    s1 = 1'b0;
      BUS_SUSP:   s1 = 1'b1;
      BUS_RESUME: s1 = !transition && high_phase;
      BUS_ACTIVE: s1 = high_phase;
      default:    s1 = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_bit_q   <= 1'b0;
    end else begin
      rx_valid_q <= sample_hit;
      if (sample_hit) rx_bit_q <= s2_i;
    end
  end

  assign rx_valid = rx_valid_q;
  assign rx_bit   = rx_bit_q;

  // R6: an accepted bit is always followed by an active period
  p_ready_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (state == BUS_ACTIVE));

  // R7: received strobes only follow active cycles
  p_rx_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> ($past(state) == BUS_ACTIVE));

  // R7: sample taken while the line is high
  p_sample_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hit |-> s1);

  // R4: the line never rises inside a running period
  p_no_mid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BUS_ACTIVE && !period_end && !s1) |=> (!s1 || state != BUS_ACTIVE));

endmodule

// File: rtl/swl_line_ctrl.sv
module swl_line_ctrl #(
  parameter int QW          = 6,
  parameter int RESUME_IDLE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] quarter_len,
  input  logic          link_en_i,
  input  logic          resume_i,
  input  logic          suspend_i,
  input  logic          deact_i,
  input  logic          wake_clr_i,
  input  logic          tx_valid_i,
  input  logic          tx_bit_i,
  output logic          tx_ready_o,
  input  logic          s2_i,
  output logic          s1_o,
  output logic          rx_valid_o,
  output logic          rx_bit_o,
  output logic [1:0]    bus_state_o,
  output logic          wake_o
);
  import swl_pkg::*;

  bus_state_e    state, state_nxt;
  logic          transition;
  logic          run;
  logic [QW+1:0] cnt;
  logic          period_end;

  assign run = (state == BUS_RESUME) || (state == BUS_ACTIVE);

  swl_bit_timer #(.QW(QW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .quarter_len (quarter_len),
    .state       (state),
    .cnt         (cnt),
    .period_end  (period_end)
  );

  swl_bus_fsm #(.RESUME_IDLE(RESUME_IDLE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_en     (link_en_i),
    .resume_req  (resume_i),
    .suspend_req (suspend_i),
    .deact_req   (deact_i),
    .wake_clr    (wake_clr_i),
    .s2_i        (s2_i),
    .period_end  (period_end),
    .state       (state),
    .state_nxt   (state_nxt),
    .transition  (transition),
    .wake        (wake_o)
  );

  swl_line_shaper #(.QW(QW)) u_shaper (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .state_nxt   (state_nxt),
    .transition  (transition),
    .cnt         (cnt),
    .period_end  (period_end),
    .quarter_len (quarter_len),
    .tx_valid    (tx_valid_i),
    .tx_bit      (tx_bit_i),
    .s2_i        (s2_i),
    .tx_ready    (tx_ready_o),
    .s1          (s1_o),
    .rx_valid    (rx_valid_o),
    .rx_bit      (rx_bit_o)
  );

  assign bus_state_o = state;

  // R9: off state always drives the line low
  p_off_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state_o == 2'd0) |-> !s1_o);

endmodule

// File: tb/sim_swl_line_ctrl.sv
module sim_swl_line_ctrl;
  localparam int QW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [QW-1:0] quarter_len = '0;
  logic link_en_i = 0, resume_i = 0, suspend_i = 0, deact_i = 0, wake_clr_i = 0;
  logic tx_valid_i = 0, tx_bit_i = 0, s2_i = 0;
  logic tx_ready_o, s1_o, rx_valid_o, rx_bit_o, wake_o;
  logic [1:0] bus_state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  swl_line_ctrl #(.QW(QW), .RESUME_IDLE(8)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts at the negedge of a period's first clock; ends at the next period's first negedge.
  task automatic run_period(input int q, input int exp_high, input bit exp_ready,
                            input bit exp_rx, input bit s2d, input bit nv, input bit nb);
    int highs = 0, readies = 0, rxs = 0, rxbit = 0;
    bit first = 0, last_ready = 0, bad_shape = 0;
    tx_valid_i = nv; tx_bit_i = nb; s2_i = s2d;
    for (int i = 0; i < 4*q; i++) begin
      if (i == 0) first = s1_o;
      if (s1_o) begin
        highs++;
        if (i >= exp_high) bad_shape = 1;
      end
      if (tx_ready_o) readies++;
      if (i == 4*q-1) last_ready = tx_ready_o;
      if (rx_valid_o) begin
        rxs++; rxbit = rx_bit_o;
        chk(i == q/2 + 1, "R7 strobe position", i, q/2 + 1);
      end
      @(negedge clk);
    end
    s2_i = 0;
    chk(highs == exp_high, "R4 high clocks", highs, exp_high);
    chk(!bad_shape && (exp_high == 0 || first), "R4 high phase at period start", int'(bad_shape), 0);
    chk(readies == int'(exp_ready) && last_ready == exp_ready, "R6 ready pulse", readies, int'(exp_ready));
    chk(rxs == int'(exp_rx), "R7 strobe count", rxs, int'(exp_rx));
    if (exp_rx) chk(rxbit == int'(s2d), "R7 sampled value", rxbit, int'(s2d));
  endtask

  initial begin
    int qs[4] = '{1, 2, 3, 5};
    foreach (qs[n]) begin
      int q = qs[n];
      bit pv, pb;
      quarter_len = QW'(q);
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(bus_state_o == 2'd0 && !s1_o && !tx_ready_o && !rx_valid_o && !wake_o,
          "R1 reset state", int'(bus_state_o), 0);

      // R10: slave current while off
      s2_i = 1;
      repeat (3) @(negedge clk);
      chk(bus_state_o == 2'd0 && !wake_o && !s1_o, "R10 off ignores s2", int'(bus_state_o), 0);
      s2_i = 0;

      link_en_i = 1; @(negedge clk); link_en_i = 0;
      chk(bus_state_o == 2'd1 && s1_o, "R2 suspended, line high", int'(bus_state_o), 1);
      repeat (3) @(negedge clk);
      chk(s1_o && bus_state_o == 2'd1, "R2 suspended line held", int'(s1_o), 1);

      // R3: master resume
      resume_i = 1; @(negedge clk); resume_i = 0;
      chk(bus_state_o == 2'd2, "R3 resuming code", int'(bus_state_o), 2);
      run_period(q, 0, 0, 0, 0, 0, 0);
      for (int k = 1; k <= 8; k++) begin
        run_period(q, q, k == 8, 0, 0, 1, 1);
        if (k < 8) chk(bus_state_o == 2'd2, "R3 still resuming", int'(bus_state_o), 2);
      end
      chk(bus_state_o == 2'd3, "R3 active after idle bits", int'(bus_state_o), 3);
      pv = 1; pb = 1;

      // R4 R5 R6 R7: data pattern sweep
      for (int k = 0; k < 6; k++) begin
        bit v  = (k % 3) != 2;
        bit b  = ((k * 5 + q) >> 1) & 1;
        bit sd = (k + q) & 1;
        run_period(q, (pv && pb) ? 3*q : q, 1, 1, sd, v, b);
        pv = v; pb = b;
      end

      // R9: suspend at the end of the period
      suspend_i = 1;
      run_period(q, (pv && pb) ? 3*q : q, 0, 1, 0, 1, 1);
      suspend_i = 0;
      chk(bus_state_o == 2'd1 && s1_o, "R9 suspend at period end", int'(bus_state_o), 1);

      // R8: slave resume
      s2_i = 1; @(negedge clk); s2_i = 0;
      chk(bus_state_o == 2'd3 && wake_o, "R8 slave resume to active", int'(bus_state_o), 3);
      run_period(q, q, 1, 1, 0, 0, 1);
      chk(wake_o, "R8 wake flag sticky", int'(wake_o), 1);
      // R5: previous offer had tx_valid low, so this period is idle

      // R9: deact wins over suspend, R8 clear
      deact_i = 1; suspend_i = 1; wake_clr_i = 1;
      run_period(q, q, 0, 1, 1, 0, 0);
      deact_i = 0; suspend_i = 0; wake_clr_i = 0;
      chk(bus_state_o == 2'd0 && !s1_o, "R9 deact priority", int'(bus_state_o), 0);
      chk(!wake_o, "R8 wake cleared", int'(wake_o), 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule